// File: doc/BRIEF.md
# Return Frame Restore Checker

On a procedure return the caller's frame marker is normally brought back from the saved previous-function-state value. This block stands on that path and decides whether the restore is safe. It compares the output area that the saved marker describes (saved frame size minus saved local size) with the stacked registers that are not dirty (physical stacked count minus dirty count). If the output area is larger, the block installs an all-zero frame marker and raises a bad-state flag. Otherwise it installs the saved marker unchanged.

The decision is combinational and is valid in the same cycle as the return strobe. The installed marker is also captured into a frame-marker register on that clock edge. The pointer and rename-base updates of the normal return path are not computed here. The block passes an enable for them that follows the return strobe on both paths. The difference is taken in widened signed arithmetic, so a saved local size larger than the saved frame size gives a negative output area. It does not wrap to a large positive one.

Frame marker layout (38 bits, LSB first): frame size [6:0], local size [13:7], rotating size [17:14], general rename base [24:18], floating rename base [31:25], predicate rename base [37:32].

Top module: `frame_restore_chk`

## Requirements
- R1: While `rst_n` is low, `cfm_q` reads all zeros.
- R2: In a return cycle where (saved_sof − saved_sol) ≤ (N_PHYS − dirty_cnt), `cfm_nxt` equals `saved_pfm` bit for bit and `bad_ret` is 0.
- R3: In a return cycle where (saved_sof − saved_sol) > (N_PHYS − dirty_cnt), `bad_ret` is 1 and every field of `cfm_nxt` is zero.
- R4: At the boundary the comparison is strict. An output area exactly equal to the free register count restores. One register more takes the zero path.
- R5: When saved_sol exceeds saved_sof and dirty_cnt ≤ N_PHYS, the negative output area never raises `bad_ret`.
- R6: `bad_ret` is 0 in every cycle where `ret_valid` is 0, whatever the other inputs are.
- R7: `ptr_upd_en` equals `ret_valid` in every cycle, on both the restore path and the zero path.
- R8: On a clock edge with `ret_valid` high, `cfm_q` takes the value `cfm_nxt` had before the edge. On an edge with `ret_valid` low, `cfm_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | A return is being executed this cycle |
| saved_sof | input | SZ_W | Frame size field of the saved state |
| saved_sol | input | SZ_W | Local size field of the saved state |
| saved_pfm | input | 38 | Saved previous frame marker |
| dirty_cnt | input | CNT_W | Current dirty stacked-register count |
| cfm_nxt | output | 38 | Frame marker to install |
| cfm_q | output | 38 | Installed frame marker register |
| bad_ret | output | 1 | Zero-marker path taken on this return |
| ptr_upd_en | output | 1 | Enable for the normal return's pointer and rename-base updates |

## Verification
The assertions check these rules on every cycle:
- the zero marker on a flagged return;
- restoration of the saved marker on an unflagged return;
- silence of the flag outside returns;
- the absence of false triggering when the local size exceeds the frame size;
- the load-or-hold behaviour of the marker register.

Only the bench's scenarios show that the threshold sits exactly at equality (R4), and that a sequence of mixed good and bad returns leaves the register with the right value. The bench also covers the reset value and the pointer-update enable on both paths, with fixed corner cases and a run of pseudo-random returns.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int FM_SOF_W = 7;
  localparam int FM_SOL_W = 7;
  localparam int FM_SOR_W = 4;
  localparam int FM_RGR_W = 7;
  localparam int FM_RFR_W = 7;
  localparam int FM_RPR_W = 6;
  localparam int FM_W = FM_SOF_W + FM_SOL_W + FM_SOR_W + FM_RGR_W + FM_RFR_W + FM_RPR_W;

  typedef struct packed {
    logic [FM_RPR_W-1:0] rrb_pr;
    logic [FM_RFR_W-1:0] rrb_fr;
    logic [FM_RGR_W-1:0] rrb_gr;
    logic [FM_SOR_W-1:0] sor;
    logic [FM_SOL_W-1:0] sol;
    logic [FM_SOF_W-1:0] sof;
  } frame_marker_t;
endpackage

// File: rtl/frc_room_calc.sv
module frc_room_calc #(
  parameter int N_PHYS = 96,
  parameter int SZ_W   = 7,
  parameter int CNT_W  = 7
) (
  input  logic [SZ_W-1:0]  sof_i,
  input  logic [SZ_W-1:0]  sol_i,
  input  logic [CNT_W-1:0] dirty_i,
  output logic             overflow_o
);
  localparam int BASE_W = (SZ_W > CNT_W) ? SZ_W : CNT_W;
  localparam int CMP_W  = BASE_W + 2;

  logic signed [CMP_W-1:0] out_area;
  logic signed [CMP_W-1:0] free_regs;

  always_comb begin
    out_area   = signed'(CMP_W'(sof_i)) - signed'(CMP_W'(sol_i));
    free_regs  = signed'(CMP_W'(N_PHYS)) - signed'(CMP_W'(dirty_i));
    overflow_o = (out_area > free_regs);
  end
endmodule

// File: rtl/frc_marker_sel.sv
module frc_marker_sel
  import frc_pkg::*;
(
  input  logic [FM_W-1:0] saved_i,
  input  logic            zero_i,
  output logic [FM_W-1:0] mark_o
);
  frame_marker_t saved_s;
  frame_marker_t mark_s;

  always_comb begin
    saved_s = frame_marker_t'(saved_i);
    mark_s  = saved_s;
    if (zero_i) begin
      mark_s.sof    = '0;
      mark_s.sol    = '0;
      mark_s.sor    = '0;
      mark_s.rrb_gr = '0;
      mark_s.rrb_fr = '0;
      mark_s.rrb_pr = '0;
    end
    mark_o = mark_s;
  end
endmodule

// File: rtl/frame_restore_chk.sv
module frame_restore_chk
  import frc_pkg::*;
#(
  parameter int N_PHYS = 96,
  parameter int SZ_W   = 7,
  localparam int CNT_W = $clog2(N_PHYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid,
  input  logic [SZ_W-1:0]  saved_sof,
  input  logic [SZ_W-1:0]  saved_sol,
  input  logic [FM_W-1:0]  saved_pfm,
  input  logic [CNT_W-1:0] dirty_cnt,
  output logic [FM_W-1:0]  cfm_nxt,
  output logic [FM_W-1:0]  cfm_q,
  output logic             bad_ret,
  output logic             ptr_upd_en
);
  logic            overflow;
  logic [FM_W-1:0] cfm_d;
  logic            cfm_en;

  frc_room_calc #(.N_PHYS(N_PHYS), .SZ_W(SZ_W), .CNT_W(CNT_W)) u_room (
    .sof_i      (saved_sof),
    .sol_i      (saved_sol),
    .dirty_i    (dirty_cnt),
    .overflow_o (overflow)
  );

  frc_marker_sel u_sel (
    .saved_i (saved_pfm),
    .zero_i  (overflow),
    .mark_o  (cfm_nxt)
  );

  always_comb begin
    bad_ret    = ret_valid & overflow;
    ptr_upd_en = ret_valid;
    cfm_en     = ret_valid;
    cfm_d      = cfm_en ? cfm_nxt : cfm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfm_q <= '0;
    else        cfm_q <= cfm_d;
  end

  // R3: a flagged return installs an all-zero marker
  assert_zero_on_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ret |-> (cfm_nxt == '0));
  // R2: an unflagged return restores the saved marker
  assert_restore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !bad_ret) |-> (cfm_nxt == saved_pfm));
  // R6: flag stays low outside a return
  assert_flag_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |-> !bad_ret);
  // R5: negative output area never flags
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && (saved_sol > saved_sof) && (int'(dirty_cnt) <= N_PHYS)) |-> !bad_ret);
  // R8: register loads on a return
  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (cfm_q == $past(cfm_nxt)));
  // R8: register holds without a return
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> $stable(cfm_q));
endmodule

// File: tb/sim_frame_restore_chk.sv
module sim_frame_restore_chk;
  import frc_pkg::*;
  localparam int N_PHYS = 96;
  localparam int SZ_W   = 7;
  localparam int CNT_W  = $clog2(N_PHYS + 1);

  typedef struct {
    logic            ret;
    logic            bad;
    logic [FM_W-1:0] nxt;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ret_valid;
  logic [SZ_W-1:0]  saved_sof;
  logic [SZ_W-1:0]  saved_sol;
  logic [FM_W-1:0]  saved_pfm;
  logic [CNT_W-1:0] dirty_cnt;
  logic [FM_W-1:0]  cfm_nxt;
  logic [FM_W-1:0]  cfm_q;
  logic             bad_ret;
  logic             ptr_upd_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  exp_t sbq[$];
  logic [FM_W-1:0] model_q;

  always #10 clk = ~clk;

  frame_restore_chk #(.N_PHYS(N_PHYS), .SZ_W(SZ_W)) u0 (
    .clk, .rst_n, .ret_valid, .saved_sof, .saved_sol, .saved_pfm,
    .dirty_cnt, .cfm_nxt, .cfm_q, .bad_ret, .ptr_upd_en
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes its expectation
  task automatic apply(input logic r, input int sof, input int sol,
                       input int dirty, input logic [FM_W-1:0] pfm);
    exp_t e;
    @(negedge clk);
    ret_valid = r;
    saved_sof = SZ_W'(sof);
    saved_sol = SZ_W'(sol);
    dirty_cnt = CNT_W'(dirty);
    saved_pfm = pfm;
    e.ret = r;
    e.bad = r && ((sof - sol) > (N_PHYS - dirty));
    e.nxt = ((sof - sol) > (N_PHYS - dirty)) ? '0 : pfm;
    sbq.push_back(e);
  endtask

  function automatic logic [FM_W-1:0] mk(input int sof, input int sol, input int tag);
    frame_marker_t m;
    m.sof = FM_SOF_W'(sof); m.sol = FM_SOL_W'(sol); m.sor = FM_SOR_W'(tag);
    m.rrb_gr = FM_RGR_W'(tag + 3); m.rrb_fr = FM_RFR_W'(tag + 5); m.rrb_pr = FM_RPR_W'(tag + 1);
    return m;
  endfunction

  // monitor: compares the design against the scoreboard
  initial begin
    model_q = '0;
    forever begin
      @(negedge clk);
      #5;
      if (rst_n === 1'b1 && sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check("R8 cfm_q", 64'(cfm_q), 64'(model_q));
        check("R7 ptr_upd_en", 64'(ptr_upd_en), 64'(e.ret));
        if (e.ret) begin
          check(e.bad ? "R3 bad_ret" : "R2 bad_ret", 64'(bad_ret), 64'(e.bad));
          check(e.bad ? "R3 cfm_nxt" : "R2 cfm_nxt", 64'(cfm_nxt), 64'(e.nxt));
          model_q = e.nxt;
        end else begin
          check("R6 bad_ret idle", 64'(bad_ret), 64'(0));
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; ret_valid = 1'b0; saved_sof = '0; saved_sol = '0;
    saved_pfm = '1; dirty_cnt = '0;
    repeat (2) @(negedge clk);
    #5 check("R1 reset cfm_q", 64'(cfm_q), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b1, 20, 10, 50, mk(20, 10, 2));   // R2 normal restore
    apply(1'b0, 30, 0, 96, mk(30, 0, 4));     // R6 bad condition but idle
    apply(1'b1, 40, 30, 86, mk(40, 30, 6));   // R4 equal -> restore
    apply(1'b1, 40, 30, 87, mk(40, 30, 7));   // R4 one over -> R3 zero
    apply(1'b0, 1, 0, 0, mk(1, 0, 1));        // R8 hold
    apply(1'b1, 5, 30, 96, mk(5, 30, 9));     // R5 sol > sof
    apply(1'b1, 1, 0, 96, mk(1, 0, 3));       // R3 full dirty
    apply(1'b1, 96, 0, 0, mk(96, 0, 8));      // R4 whole file free
    apply(1'b1, 0, 0, 96, mk(0, 0, 11));      // R2 empty output area
    for (int i = 0; i < 300; i++) begin
      int s, l, d;
      s = int'($urandom_range(96, 0));
      l = int'($urandom_range(s + 8 > 127 ? 127 : s + 8, 0));
      d = int'($urandom_range(N_PHYS, 0));
      apply(1'($urandom_range(1, 0)), s, l, d, mk(s, l, i));
    end
    apply(1'b0, 0, 0, 0, '0);
    apply(1'b0, 0, 0, 0, '0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule